// File: doc/BRIEF.md
# Single-Pin Echoing Serial Link

This block is the serial front end of a debug monitor that talks to a host over one shared, open line. It receives and transmits frames on that line. Each frame is non-return-to-zero: a low start bit, eight data bits with the least significant first, and a high stop bit. Receive and transmit use one bit period, taken from a bus-clock divider. The default period is 278 clock cycles.

Every byte received correctly is sent back on the same line after a guard time, so the host can confirm what the monitor heard. Some frames are all low with no stop bit: the start bit and the nine bits after it stay low. Such a frame is a break. The link answers it by driving the line high for the guard time, then sending back ten low bits. Command logic takes received bytes and break events as one-cycle strobes. It can also hand the link a byte to send, such as read data, through a valid/ready handshake. The pad is a split bidirectional pin: an input, an output value and an output enable.

Top module: `monitor_serial_link`

## Requirements
- R1: After reset the output enable is low, the output value is high, both receive strobes are low and `tx_ready` is high.
- R2: A frame with start bit 0, data bits sent LSB first and stop bit 1 raises `rx_valid` for exactly one cycle, with the byte on `rx_data`. Each bit is sampled at its midpoint.
- R3: The echo of a received byte starts GUARD_BITS*BIT_CYCLES+1 cycles after the `rx_valid` cycle. The line is not driven during the guard.
- R4: A transmitted byte frame is line_o = 0 for one bit, then the data bits LSB first, then 1 for one bit. Each bit lasts BIT_CYCLES cycles, and the output enable falls right after the stop bit.
- R5: A low pulse that ends before the midpoint of a start bit is rejected. It gives no strobe and no transmission.
- R6: Ten low bit periods followed by a return high give one `rx_break` pulse once the line is high again, and no `rx_valid`.
- R7: After a break the link drives the line high for GUARD_BITS*BIT_CYCLES cycles. It then drives it low for 10*BIT_CYCLES cycles and releases it.
- R8: A frame whose stop bit is low and whose data is not all zero is discarded. It gives no strobe and no transmission.
- R9: While the link is busy transmitting, including the guard time, activity on the line gives no receive strobe.
- R10: A request with `tx_valid` high while `tx_ready` is high is sent as a byte frame after the guard time. `tx_ready` stays low until that frame ends, and a request made while it is low is dropped.
- R11: A new frame that begins one bit period after an echo ends is received correctly.
- R12: The output enable is high only while transmitting. Whenever it is low, `line_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Pad input value |
| line_o | output | 1 | Pad output value |
| line_oe | output | 1 | Pad output enable |
| tx_valid | input | 1 | Command logic offers a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Link can accept a send request |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: byte received |
| rx_break | output | 1 | One-cycle strobe: break received |

## Verification
The hardest condition to reach from the ports is the one where the line toggles while the receiver is gated off. The host can only drive the line when the link is not driving it, and that is true only during the undriven guard before an echo. The bench therefore drives a half-bit low pulse straight after a frame's stop bit, inside that guard window. It then checks that the echo is intact and that no extra byte appears. The break response needs a frame that is low for its full length. The bench also sweeps every byte value through receive and echo, with each new frame sent one bit after the previous echo.

// File: rtl/mlink_pkg.sv
package mlink_pkg;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_GUARD, TX_SHIFT} tx_state_e;
endpackage

// File: rtl/mlink_rx.sv
module mlink_rx
  import mlink_pkg::*;
#(
  parameter int BIT_CYCLES = 278
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       line_i,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_break,
  output logic       busy
);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(BIT_CYCLES / 2 - 1);

  rx_state_e     state;
  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [7:0]    shreg;
  logic          brk_pend;

  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      brk_pend <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_break <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_break <= 1'b0;
      case (state)
        RX_IDLE: if (en && !s2) begin
          cnt   <= HALF_LAST;
          state <= RX_START;
        end
        RX_START: if (cnt == '0) begin
          if (!s2) begin
            cnt   <= BIT_LAST;
            idx   <= '0;
            state <= RX_BITS;
          end else begin
            state <= RX_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        RX_BITS: if (cnt == '0) begin
          cnt <= BIT_LAST;
          if (idx == 4'd8) begin
            if (s2) begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
            end else begin
              brk_pend <= (shreg == 8'h00);
            end
            state <= RX_HOLD;
          end else begin
            shreg <= {s2, shreg[7:1]};
            idx   <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        RX_HOLD: if (s2) begin
          rx_break <= brk_pend;
          brk_pend <= 1'b0;
          state    <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_break_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rx_break |=> !rx_break);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_break));
endmodule

// File: rtl/mlink_tx.sv
module mlink_tx
  import mlink_pkg::*;
#(
  parameter int BIT_CYCLES = 278,
  parameter int GUARD_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       brk,
  input  logic [7:0] data,
  output logic       line_o,
  output logic       line_oe,
  output logic       busy
);
  localparam int GUARD_CYCLES = GUARD_BITS * BIT_CYCLES;
  localparam int CMAX = (GUARD_CYCLES > BIT_CYCLES) ? GUARD_CYCLES : BIT_CYCLES;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] BIT_LAST   = CW'(BIT_CYCLES - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CYCLES - 1);

  tx_state_e             state;
  logic [CW-1:0]         cnt;
  logic [3:0]            bitn;
  logic [FRAME_BITS-1:0] shreg;

  assign busy = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '1;
      line_o  <= 1'b1;
      line_oe <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: if (start) begin
          cnt     <= GUARD_LAST;
          shreg   <= brk ? '0 : {1'b1, data, 1'b0};
          line_oe <= brk;
          line_o  <= 1'b1;
          state   <= TX_GUARD;
        end
        TX_GUARD: if (cnt == '0) begin
          cnt     <= BIT_LAST;
          bitn    <= '0;
          line_oe <= 1'b1;
          line_o  <= shreg[0];
          shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
          state   <= TX_SHIFT;
        end else begin
          cnt <= cnt - 1'b1;
        end
        TX_SHIFT: if (cnt == '0) begin
          if (bitn == 4'(FRAME_BITS - 1)) begin
            line_oe <= 1'b0;
            line_o  <= 1'b1;
            state   <= TX_IDLE;
          end else begin
            cnt    <= BIT_LAST;
            bitn   <= bitn + 1'b1;
            line_o <= shreg[0];
            shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  p_mark_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> line_o);
  p_bit_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (state == TX_SHIFT && $past(state) == TX_SHIFT && cnt != BIT_LAST)
      |-> $stable(line_o));
  p_oe_busy_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_oe);
endmodule

// File: rtl/monitor_serial_link.sv
module monitor_serial_link
  import mlink_pkg::*;
#(
  parameter int BIT_CYCLES = 278,
  parameter int GUARD_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  output logic       line_o,
  output logic       line_oe,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_break
);
  logic       rx_busy, tx_busy;
  logic       go;
  logic [7:0] go_data;

  mlink_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
    .clk(clk), .rst(rst), .en(!tx_busy), .line_i(line_i),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break),
    .busy(rx_busy)
  );

  assign tx_ready = !tx_busy && !rx_busy && !rx_break;
  assign go       = rx_valid || rx_break || (tx_valid && tx_ready);
  assign go_data  = rx_valid ? rx_data : tx_data;

  mlink_tx #(.BIT_CYCLES(BIT_CYCLES), .GUARD_BITS(GUARD_BITS)) u_tx (
    .clk(clk), .rst(rst), .start(go), .brk(rx_break), .data(go_data),
    .line_o(line_o), .line_oe(line_oe), .busy(tx_busy)
  );

  p_rx_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> !(rx_valid || rx_break));
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !line_oe);
  p_busy_after_go_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: tb/monitor_serial_link_tb.sv
module monitor_serial_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 8;
  localparam int GB = 2;
  localparam int G = GB * BIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host = 1'b1;
  logic line_o, line_oe, tx_ready, rx_valid, rx_break;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  wire line_i = line_oe ? line_o : host;

  int nchk = 0, nfail = 0;
  int cyc = 0, nvalid = 0, nbreak = 0, noe = 0, mark_bad = 0;
  int t_valid = 0, t_oe = 0;
  logic [7:0] last_rx = 8'h00;
  logic oe_q = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  monitor_serial_link #(.BIT_CYCLES(BIT), .GUARD_BITS(GB)) u_dut (
    .clk(clk), .rst(rst), .line_i(line_i), .line_o(line_o), .line_oe(line_oe),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) if (!rst) begin
    if (rx_valid) begin nvalid++; t_valid = cyc; last_rx = rx_data; end
    if (rx_break) nbreak++;
    if (line_oe && !oe_q) begin noe++; t_oe = cyc; end
    oe_q = line_oe;
    if (!line_oe && !line_o) mark_bad++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_bits(input logic [9:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      host = bits[i];
      repeat (BIT) @(negedge clk);
    end
    host = 1'b1;
  endtask

  task automatic wait_oe(output bit ok);
    int w = 0;
    while (!line_oe && w < 4000) begin @(negedge clk); w++; end
    ok = line_oe;
  endtask

  task automatic capture(output logic [9:0] got, output bit ok, output bit rel);
    wait_oe(ok);
    got = '1;
    repeat (BIT/2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      got[i] = line_o;
      repeat (BIT) @(negedge clk);
    end
    rel = !line_oe;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    logic [9:0] got;
    bit ok, rel;
    int nv0, nb0, no0, hi, lo;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!line_oe && line_o && !rx_valid && !rx_break && tx_ready, "R1 reset",
          {line_oe, line_o, rx_valid, rx_break, tx_ready}, 5'b01001);
    repeat (BIT) @(negedge clk);

    // R2 R3 R4 R9 R11: every byte, each sent one bit after the previous echo
    for (int b = 0; b < 256; b++) begin
      nv0 = nvalid;
      host_bits({1'b1, 8'(b), 1'b0}, 10);
      if (b % 16 == 0) begin
        host = 1'b0;                       // R9 pulse inside the guard time
        repeat (BIT/2) @(negedge clk);
        host = 1'b1;
      end
      check(nvalid == nv0 + 1 && last_rx == 8'(b), "R2 receive", last_rx, b);
      capture(got, ok, rel);
      check(ok && got == {1'b1, 8'(b), 1'b0}, "R4 echo frame", got, {1'b1, 8'(b), 1'b0});
      check(t_oe - t_valid == G + 1, "R3 guard", t_oe - t_valid, G + 1);
      check(rel, "R4 release", line_oe, 0);
      if (b % 16 == 0)
        check(nvalid == nv0 + 1, "R9 ignored while busy", nvalid - nv0, 1);
      repeat (BIT/2) @(negedge clk);     // R11: one bit after echo end
    end

    // R5 short glitch
    nv0 = nvalid; nb0 = nbreak; no0 = noe;
    host = 1'b0; repeat (BIT/4) @(negedge clk); host = 1'b1;
    repeat (14*BIT) @(negedge clk);
    check(nvalid == nv0 && nbreak == nb0 && noe == no0, "R5 glitch",
          nvalid - nv0 + nbreak - nb0 + noe - no0, 0);

    // R8 framing error with nonzero data
    nv0 = nvalid; nb0 = nbreak; no0 = noe;
    host_bits({1'b0, 8'h5A, 1'b0}, 10);
    repeat (14*BIT) @(negedge clk);
    check(nvalid == nv0 && nbreak == nb0 && noe == no0, "R8 framing",
          nvalid - nv0 + nbreak - nb0 + noe - no0, 0);

    // R6 R7 break
    nv0 = nvalid; nb0 = nbreak;
    host_bits(10'b0, 10);
    wait_oe(ok);
    check(nbreak == nb0 + 1 && nvalid == nv0, "R6 break strobe", nbreak - nb0, 1);
    hi = 0; lo = 0;
    while (line_oe && line_o && hi < 4000) begin hi++; @(negedge clk); end
    while (line_oe && !line_o && lo < 4000) begin lo++; @(negedge clk); end
    check(ok && hi == G, "R7 high pulse", hi, G);
    check(lo == 10*BIT, "R7 low bits", lo, 10*BIT);
    check(!line_oe, "R7 release", line_oe, 0);
    repeat (3*BIT) @(negedge clk);

    // R10 command-side sends
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      d = 8'(k * 17) ^ 8'hC3;
      nv0 = nvalid;
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_data = d;
      @(negedge clk);
      tx_valid = 1'b0;
      check(!tx_ready, "R10 ready low when busy", tx_ready, 0);
      tx_valid = 1'b1; tx_data = ~d;           // dropped request
      @(negedge clk);
      tx_valid = 1'b0;
      capture(got, ok, rel);
      no0 = noe;
      check(ok && got == {1'b1, d, 1'b0}, "R10 send frame", got, {1'b1, d, 1'b0});
      repeat (4*BIT) @(negedge clk);
      check(noe == no0 && nvalid == nv0, "R10 dropped request", noe - no0, 0);
    end

    check(mark_bad == 0, "R12 idle mark", mark_bad, 0);
    summary();
  end
endmodule